// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block is an in-order retirement queue for a speculative out-of-order core. Instructions enter it in program order at issue time and each receives a slot tag. Execution units that finish out of order post their result against that tag. The oldest slot leaves the buffer only after its result has arrived, and at that point the block directs the result to the register file, to memory, or to neither, depending on the kind of instruction the slot holds.

Each slot records one of three kinds: a register-writing instruction, whose destination field holds a register number; a store, whose destination field holds a memory address; or a branch, which has no destination. A branch result carries a mispredict flag. When a mispredicted branch retires, the block raises a one-cycle flush and discards every slot, so the wrong-path work never becomes architectural state.

Allocation and retirement are valid/ready streams. The issue side may hold `alloc_valid` for as long as it likes: a slot is taken only in a cycle where `alloc_ready` is also high. The retire side presents the oldest completed slot on `cm_valid`, and the consumer can apply back-pressure by holding `cm_ready` low. While it does so the presented slot does not change. Result writeback is a plain strobe and cannot be refused.

Top module: `spec_rob`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `alloc_tag` is 0, and `cm_valid`, `cm_reg_we`, `cm_mem_we` and `flush` are 0.
- R2: A slot is taken exactly when `alloc_valid` and `alloc_ready` are both high. It receives the tag shown on `alloc_tag` in that cycle, and tags are handed out in increasing order, wrapping from DEPTH-1 to 0.
- R3: The buffer never holds more than DEPTH slots. `alloc_ready` is 0 whenever DEPTH slots are occupied, and also whenever the oldest slot is a completed branch with its mispredict flag set.
- R4: A writeback (`wb_valid`, `wb_tag`) marks the addressed slot complete and records `wb_value` and `wb_mispred`. A writeback to a tag that is not occupied, or whose slot is already complete, has no effect.
- R5: `cm_valid` is 1 only when the oldest slot is complete. Slots retire strictly in allocation order, at most one per cycle, and a slot retires in a cycle where `cm_valid` and `cm_ready` are both high.
- R6: While `cm_valid` is 1 and `cm_ready` is 0, the presented slot (its tag, kind, destination and value) stays unchanged into the next cycle.
- R7: Kind encoding on `alloc_kind` and `cm_kind` is 0 for register, 1 for store and 2 for branch. When a register slot retires, `cm_reg_we` pulses. When a store retires, `cm_mem_we` pulses. When a branch retires, neither strobe pulses.
- R8: When a branch whose mispredict flag is set retires, `flush` is 1 in that cycle. In the next cycle the buffer is empty and `alloc_tag` is 0.
- R9: A branch that retires with its mispredict flag clear produces no flush, and the younger slots stay in the buffer.
- R10: A retiring slot presents on `cm_tag`, `cm_dest` and `cm_value` its own tag, the destination given at allocation, and the value given at writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Issue side offers an instruction |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_kind | input | 2 | Kind of the offered instruction (0 register, 1 store, 2 branch) |
| alloc_dest | input | DEST_W | Register number or memory address |
| alloc_tag | output | $clog2(DEPTH) | Tag the offered instruction receives |
| wb_valid | input | 1 | Result writeback strobe |
| wb_tag | input | $clog2(DEPTH) | Slot the result belongs to |
| wb_value | input | DATA_W | Result value |
| wb_mispred | input | 1 | Branch outcome was mispredicted |
| cm_valid | output | 1 | Oldest slot is complete and presented |
| cm_ready | input | 1 | Consumer accepts the presented slot |
| cm_kind | output | 2 | Kind of the presented slot |
| cm_tag | output | $clog2(DEPTH) | Tag of the presented slot |
| cm_dest | output | DEST_W | Destination of the presented slot |
| cm_value | output | DATA_W | Value of the presented slot |
| cm_reg_we | output | 1 | Register file write strobe for a retiring register slot |
| cm_mem_we | output | 1 | Memory write strobe for a retiring store |
| flush | output | 1 | A mispredicted branch retires and all slots are discarded |

## Verification
The bound checker watches several properties on every cycle. It checks the occupancy bound and that a full buffer refuses allocation. It checks that the register strobe, the memory strobe and the flush are mutually exclusive and only pulse on an accepted retirement. It checks that a stalled presentation holds steady, that tags advance by one per allocation, that occupancy changes by the net of allocations and retirements, and that a flush empties the buffer and rewinds the tag. Other behaviour can only be shown by the bench's cycle-accurate queue model: in-order retirement after out-of-order writebacks, values and destinations reaching the right strobe, writebacks to empty slots being dropped, and correctly predicted branches leaving younger work intact.

// File: rtl/spec_rob_pkg.sv
package spec_rob_pkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'b00,
    KIND_STORE  = 2'b01,
    KIND_BRANCH = 2'b10
  } rob_kind_e;
endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic             commit_fire,
  input  logic             flush,
  output logic [TAG_W-1:0] head,
  output logic [TAG_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  localparam logic [TAG_W-1:0] LAST = TAG_W'(DEPTH - 1);

  function automatic logic [TAG_W-1:0] bump(input logic [TAG_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (flush) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (alloc_fire)  tail <= bump(tail);
      if (commit_fire) head <= bump(head);
      count <= count + CNT_W'(alloc_fire) - CNT_W'(commit_fire);
    end
  end

  assign full = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/rob_slot.sv
module rob_slot
  import spec_rob_pkg::*;
#(
  parameter int DEST_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              alloc_en,
  input  rob_kind_e         alloc_kind,
  input  logic [DEST_W-1:0] alloc_dest,
  input  logic              wb_hit,
  input  logic [DATA_W-1:0] wb_value,
  input  logic              wb_mispred,
  input  logic              retire_en,
  output logic              valid,
  output logic              done,
  output rob_kind_e         kind,
  output logic [DEST_W-1:0] dest,
  output logic [DATA_W-1:0] value,
  output logic              mispred
);
  logic take_wb;
  assign take_wb = wb_hit && valid && !done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      done    <= 1'b0;
      kind    <= KIND_REG;
      dest    <= '0;
      value   <= '0;
      mispred <= 1'b0;
    end else if (flush) begin
      valid   <= 1'b0;
      done    <= 1'b0;
      mispred <= 1'b0;
    end else begin
      if (alloc_en) begin
        valid   <= 1'b1;
        done    <= 1'b0;
        mispred <= 1'b0;
        kind    <= alloc_kind;
        dest    <= alloc_dest;
      end else if (retire_en) begin
        valid <= 1'b0;
        done  <= 1'b0;
      end
      if (take_wb) begin
        done    <= 1'b1;
        value   <= wb_value;
        mispred <= wb_mispred;
      end
    end
  end
endmodule

// File: rtl/rob_commit_route.sv
module rob_commit_route
  import spec_rob_pkg::*;
(
  input  logic      head_valid,
  input  logic      head_done,
  input  rob_kind_e head_kind,
  input  logic      head_mispred,
  input  logic      cm_ready,
  output logic      cm_valid,
  output logic      commit_fire,
  output logic      reg_we,
  output logic      mem_we,
  output logic      flush,
  output logic      hold_alloc
);
  logic bad_branch;

  always_comb begin
    cm_valid    = head_valid && head_done;
    commit_fire = cm_valid && cm_ready;
    bad_branch  = cm_valid && (head_kind == KIND_BRANCH) && head_mispred;
    hold_alloc  = bad_branch;
    flush       = commit_fire && bad_branch;
    reg_we      = commit_fire && (head_kind == KIND_REG);
    mem_we      = commit_fire && (head_kind == KIND_STORE);
  end
endmodule

// File: rtl/spec_rob.sv
module spec_rob
  import spec_rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DEST_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_valid,
  output logic                     alloc_ready,
  input  logic [1:0]               alloc_kind,
  input  logic [DEST_W-1:0]        alloc_dest,
  output logic [$clog2(DEPTH)-1:0] alloc_tag,
  input  logic                     wb_valid,
  input  logic [$clog2(DEPTH)-1:0] wb_tag,
  input  logic [DATA_W-1:0]        wb_value,
  input  logic                     wb_mispred,
  output logic                     cm_valid,
  input  logic                     cm_ready,
  output logic [1:0]               cm_kind,
  output logic [$clog2(DEPTH)-1:0] cm_tag,
  output logic [DEST_W-1:0]        cm_dest,
  output logic [DATA_W-1:0]        cm_value,
  output logic                     cm_reg_we,
  output logic                     cm_mem_we,
  output logic                     flush
);
  localparam int TAG_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [TAG_W-1:0] head, tail;
  logic [CNT_W-1:0] occ_count;
  logic             full, hold_alloc, alloc_fire, commit_fire;

  logic              s_valid   [DEPTH];
  logic              s_done    [DEPTH];
  rob_kind_e         s_kind    [DEPTH];
  logic [DEST_W-1:0] s_dest    [DEPTH];
  logic [DATA_W-1:0] s_value   [DEPTH];
  logic              s_mispred [DEPTH];

  assign alloc_ready = !full && !hold_alloc;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_tag   = tail;

  rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_fire  (alloc_fire),
    .commit_fire (commit_fire),
    .flush       (flush),
    .head        (head),
    .tail        (tail),
    .count       (occ_count),
    .full        (full)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    rob_slot #(.DEST_W(DEST_W), .DATA_W(DATA_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .alloc_en   (alloc_fire && (tail == TAG_W'(i))),
      .alloc_kind (rob_kind_e'(alloc_kind)),
      .alloc_dest (alloc_dest),
      .wb_hit     (wb_valid && (wb_tag == TAG_W'(i))),
      .wb_value   (wb_value),
      .wb_mispred (wb_mispred),
      .retire_en  (commit_fire && (head == TAG_W'(i))),
      .valid      (s_valid[i]),
      .done       (s_done[i]),
      .kind       (s_kind[i]),
      .dest       (s_dest[i]),
      .value      (s_value[i]),
      .mispred    (s_mispred[i])
    );
  end

  rob_commit_route u_route (
    .head_valid   (s_valid[head]),
    .head_done    (s_done[head]),
    .head_kind    (s_kind[head]),
    .head_mispred (s_mispred[head]),
    .cm_ready     (cm_ready),
    .cm_valid     (cm_valid),
    .commit_fire  (commit_fire),
    .reg_we       (cm_reg_we),
    .mem_we       (cm_mem_we),
    .flush        (flush),
    .hold_alloc   (hold_alloc)
  );

  assign cm_kind  = s_kind[head];
  assign cm_tag   = head;
  assign cm_dest  = s_dest[head];
  assign cm_value = s_value[head];
endmodule

// File: rtl/spec_rob_chk.sv
module spec_rob_chk #(
  parameter int DEPTH  = 8,
  parameter int DEST_W = 32,
  parameter int DATA_W = 32,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alloc_valid,
  input logic              alloc_ready,
  input logic [TAG_W-1:0]  alloc_tag,
  input logic              cm_valid,
  input logic              cm_ready,
  input logic [TAG_W-1:0]  cm_tag,
  input logic [DEST_W-1:0] cm_dest,
  input logic [DATA_W-1:0] cm_value,
  input logic              cm_reg_we,
  input logic              cm_mem_we,
  input logic              flush,
  input logic [CNT_W-1:0]  occ_count
);
  localparam logic [TAG_W-1:0] LAST = TAG_W'(DEPTH - 1);

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    occ_count <= CNT_W'(DEPTH));

  p_full_refuses_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_count == CNT_W'(DEPTH)) |-> !alloc_ready);

  p_strobes_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cm_reg_we, cm_mem_we, flush}));

  p_strobe_needs_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_reg_we || cm_mem_we || flush) |-> (cm_valid && cm_ready));

  p_stall_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && !cm_ready) |=>
      (cm_valid && $stable(cm_tag) && $stable(cm_dest) && $stable(cm_value)));

  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (occ_count == '0) && (alloc_tag == '0) && !cm_valid);

  p_tag_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready && !flush) |=>
      (alloc_tag == (($past(alloc_tag) == LAST) ? '0 : $past(alloc_tag) + 1'b1)));

  p_count_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready && !(cm_valid && cm_ready)) |=>
      (occ_count == $past(occ_count) + 1'b1));

  p_count_shrinks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(alloc_valid && alloc_ready) && cm_valid && cm_ready && !flush) |=>
      (occ_count == $past(occ_count) - 1'b1));
endmodule

bind spec_rob spec_rob_chk #(.DEPTH(DEPTH), .DEST_W(DEST_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .alloc_valid (alloc_valid),
  .alloc_ready (alloc_ready),
  .alloc_tag   (alloc_tag),
  .cm_valid    (cm_valid),
  .cm_ready    (cm_ready),
  .cm_tag      (cm_tag),
  .cm_dest     (cm_dest),
  .cm_value    (cm_value),
  .cm_reg_we   (cm_reg_we),
  .cm_mem_we   (cm_mem_we),
  .flush       (flush),
  .occ_count   (occ_count)
);

// File: tb/spec_rob_tb.sv
`timescale 1ns/1ps
module spec_rob_tb;
  localparam int D  = 8;
  localparam int TW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          alloc_valid = 1'b0;
  logic          alloc_ready;
  logic [1:0]    alloc_kind = '0;
  logic [31:0]   alloc_dest = '0;
  logic [TW-1:0] alloc_tag;
  logic          wb_valid = 1'b0;
  logic [TW-1:0] wb_tag = '0;
  logic [31:0]   wb_value = '0;
  logic          wb_mispred = 1'b0;
  logic          cm_valid;
  logic          cm_ready = 1'b0;
  logic [1:0]    cm_kind;
  logic [TW-1:0] cm_tag;
  logic [31:0]   cm_dest;
  logic [31:0]   cm_value;
  logic          cm_reg_we;
  logic          cm_mem_we;
  logic          flush;

  always #2 clk = ~clk;

  spec_rob #(.DEPTH(D), .DEST_W(32), .DATA_W(32)) u_dut (.*);

  typedef struct {
    int          kind;
    logic [31:0] dest;
    logic [31:0] val;
    bit          rdy;
    bit          mis;
    int          tag;
  } ent_t;

  ent_t q[$];
  int   tail_m = 0;
  int   checks = 0;
  int   fails  = 0;
  bit   finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input bit av, input int ak, input logic [31:0] ad,
                      input bit wv, input int wt, input logic [31:0] wval,
                      input bit wm, input bit cr);
    bit exp_ar, exp_cv, cfire, fl, afire;
    @(negedge clk);
    alloc_valid = av;
    alloc_kind  = 2'(ak);
    alloc_dest  = ad;
    wb_valid    = wv;
    wb_tag      = TW'(wt);
    wb_value    = wval;
    wb_mispred  = wm;
    cm_ready    = cr;
    #1;
    exp_cv = (q.size() > 0) && q[0].rdy;
    exp_ar = (q.size() < D) && !(exp_cv && q[0].kind == 2 && q[0].mis);
    chk(alloc_ready == exp_ar, (q.size() == D) ? "R3" : "R2", "alloc_ready",
        alloc_ready, exp_ar);
    chk(alloc_tag == TW'(tail_m), "R2", "alloc_tag", alloc_tag, tail_m);
    chk(cm_valid == exp_cv, "R5", "cm_valid", cm_valid, exp_cv);
    cfire = exp_cv && cr;
    fl    = cfire && q[0].kind == 2 && q[0].mis;
    if (exp_cv) begin
      chk(cm_tag == TW'(q[0].tag), "R10", "cm_tag", cm_tag, q[0].tag);
      chk(cm_kind == 2'(q[0].kind), "R7", "cm_kind", cm_kind, q[0].kind);
      chk(cm_value == q[0].val, "R10", "cm_value", cm_value, q[0].val);
      if (q[0].kind != 2)
        chk(cm_dest == q[0].dest, "R10", "cm_dest", cm_dest, q[0].dest);
    end
    chk(cm_reg_we == (cfire && q[0].kind == 0), "R7", "cm_reg_we", cm_reg_we,
        cfire && q[0].kind == 0);
    chk(cm_mem_we == (cfire && q[0].kind == 1), "R7", "cm_mem_we", cm_mem_we,
        cfire && q[0].kind == 1);
    chk(flush == fl, "R8", "flush", flush, fl);
    afire = av && exp_ar;
    if (fl) begin
      q.delete();
      tail_m = 0;
    end else begin
      if (wv)
        foreach (q[k])
          if (q[k].tag == wt && !q[k].rdy) begin
            q[k].rdy = 1'b1;
            q[k].val = wval;
            q[k].mis = wm;
          end
      if (cfire) void'(q.pop_front());
      if (afire) begin
        q.push_back('{ak, ad, 32'd0, 1'b0, 1'b0, tail_m});
        tail_m = (tail_m + 1) % D;
      end
    end
  endtask

  task automatic idle(input bit cr);
    tick(0, 0, 0, 0, 0, 0, 0, cr);
  endtask

  task automatic alloc(input int k, input logic [31:0] d);
    tick(1, k, d, 0, 0, 0, 0, 0);
  endtask

  task automatic wb(input int t, input logic [31:0] v, input bit m, input bit cr);
    tick(0, 0, 0, 1, t, v, m, cr);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int held_tag;
    bit saw_flush;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    #1;
    chk(alloc_ready && alloc_tag == 0, "R1", "alloc_ready/tag", alloc_ready, 1);
    chk(!cm_valid && !cm_reg_we && !cm_mem_we && !flush, "R1", "cm idle",
        cm_valid, 0);

    // R3: fill to capacity, ninth offer refused
    for (int i = 0; i < D + 1; i++) alloc(0, 32'(100 + i));
    idle(0);
    chk(alloc_ready == 1'b0, "R3", "alloc_ready when full", alloc_ready, 0);

    // R5 R6: out-of-order completion with a stalled consumer
    wb(3, 32'h33, 0, 0);
    wb(1, 32'h11, 0, 0);
    wb(0, 32'h10, 0, 0);
    idle(0);
    held_tag = cm_tag;
    for (int i = 0; i < 3; i++) begin
      idle(0);
      chk(cm_valid && cm_tag == TW'(held_tag), "R6", "stalled cm_tag", cm_tag,
          held_tag);
    end
    wb(2, 32'h22, 0, 1);
    for (int t = 4; t < D; t++) wb(t, 32'(t * 17), 0, 1);
    repeat (10) idle(1);

    // R4: writeback to an empty slot is dropped
    wb(tail_m, 32'hdead, 0, 1);
    alloc(0, 32'd7);
    idle(1);
    chk(cm_valid == 1'b0, "R4", "stray writeback ignored", cm_valid, 0);
    wb(q[0].tag, 32'h77, 0, 1);
    repeat (3) idle(1);

    // R9: correctly predicted branch, store, register
    alloc(2, 0);
    alloc(1, 32'h4000);
    alloc(0, 32'd5);
    wb(q[0].tag, 32'h1, 0, 0);
    wb(q[1].tag, 32'haa, 0, 0);
    wb(q[2].tag, 32'hbb, 0, 0);
    for (int i = 0; i < 5; i++) begin
      idle(1);
      if (cm_valid && cm_kind == 2)
        chk(flush == 1'b0, "R9", "flush on good branch", flush, 0);
    end

    // R8: mispredicted branch flushes younger slots
    alloc(0, 32'd9);
    alloc(2, 0);
    alloc(1, 32'h5000);
    alloc(0, 32'd11);
    wb(q[2].tag, 32'hcc, 0, 0);
    wb(q[1].tag, 32'h2, 1, 0);
    wb(q[3].tag, 32'hdd, 0, 0);
    wb(q[0].tag, 32'h99, 0, 0);
    alloc(0, 32'd12);
    saw_flush = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (saw_flush) begin
        idle(1);
        chk(alloc_tag == 0 && !cm_valid, "R8", "empty after flush", alloc_tag, 0);
        saw_flush = 1'b0;
      end else begin
        idle(1);
        saw_flush = flush;
      end
    end

    // mixed random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int open[$];
      bit wv;
      int wt;
      foreach (q[k]) if (!q[k].rdy) open.push_back(q[k].tag);
      wv = (open.size() > 0) && ($urandom_range(0, 2) != 0);
      wt = wv ? open[$urandom_range(0, open.size() - 1)] : int'($urandom_range(0, D - 1));
      tick($urandom_range(0, 1), $urandom_range(0, 2), $urandom(),
           wv || ($urandom_range(0, 15) == 0), wt, $urandom(),
           $urandom_range(0, 9) == 0, $urandom_range(0, 3) != 0);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule